// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Error Interrupt Routing

This block receives asynchronous serial characters made of a low start bit, eight data bits sent least significant bit first, an optional parity bit and one high stop bit. Its bit timing comes from a free-running 12-bit prescaler. A tap select picks how often the prescaler emits a sampling tick. A programmable divider then counts those ticks to form one bit period. A falling line is confirmed as a start bit half a bit period later, and every later bit is sampled near its centre.

When a character ends, the assembled byte is always written to the receive register, even if an error was found. Parity, framing and overrun errors collect in sticky status flags. One routing input selects whether an errored character raises only the error interrupt, or the error interrupt together with the completion interrupt. Dropping the enable stops reception at once, and nothing visible changes. A byte that is left unread turns every following character into an overrun until software reads the byte.

Top module: `uart_rx_route`

## Requirements
- R1: While `rx_en` is 0 no character is accepted. Clearing `rx_en` in the middle of a character abandons it: `rx_data`, the three error flags and both interrupts stay unchanged.
- R2: With `tap_sel` = n (0 to 11), a sampling tick occurs once every 2^n clocks. One bit lasts `bit_div` ticks, so a bit is `bit_div`·2^n clocks long. `bit_div` must be at least 8.
- R3: A low line starts the half-bit counter (`bit_div`/2 ticks). If the line is high again at that point, the receiver returns to idle and reports nothing.
- R4: The first data bit after the start bit becomes `rx_data[0]` and the eighth becomes `rx_data[7]`. `rx_data` is updated one clock after the stop bit has been sampled. It resets to 0x00.
- R5: `par_mode` encodes 0 as no parity bit, 1 as even, 2 as odd and 3 as a parity bit that must be 0. Under modes 1 to 3, a parity bit that breaks the rule sets `err_par`.
- R6: A stop bit sampled low sets `err_frm`. The byte of an errored character is still written to `rx_data`.
- R7: If a character completes while the previous byte is still unread (no `buf_rd` pulse since that byte was loaded), `err_ovr` is set. This repeats for every character until `buf_rd` is pulsed.
- R8: A character without errors pulses only `irq_done`. An errored character pulses `irq_err`. It also pulses `irq_done` when `err_route` is 0, but not when `err_route` is 1.
- R9: Each interrupt is high for exactly one clock per character.
- R10: The error flags are sticky across characters and are cleared by a `stat_rd` pulse. If a new error arrives in the same clock as `stat_rd`, the new error is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; clearing it aborts a character |
| rx_in | input | 1 | Serial line, idle high |
| tap_sel | input | 4 | Prescaler tap n, a tick every 2^n clocks |
| bit_div | input | 8 | Ticks per bit period |
| par_mode | input | 2 | 0 none, 1 even, 2 odd, 3 forced zero |
| err_route | input | 1 | 1: an errored character suppresses `irq_done` |
| buf_rd | input | 1 | Pulse: the receive byte has been read |
| stat_rd | input | 1 | Pulse: the error flags have been read and are cleared |
| rx_data | output | 8 | Last received byte |
| err_par | output | 1 | Sticky parity error |
| err_frm | output | 1 | Sticky framing error |
| err_ovr | output | 1 | Sticky overrun error |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
The hardest behaviour to reach from the ports is the lasting overrun together with the silent abort. Both depend on a history of reads that were skipped, or on an enable that drops partway through a bit stream. The random phase skips the read pulses in about a quarter of the characters, so runs of unread bytes form with random routing and parity settings. Directed sequences then clear `rx_en` after a few data bits of a character full of zeros, and send a start pulse shorter than half a bit. After each of these, the bench checks that the byte, the flags and the interrupt counts did not move.

// File: rtl/urx_pkg.sv
// Shared types for the serial receiver.
// Assumes: an 8-bit character at most, and one stop bit.
package urx_pkg;
    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_ZERO = 2'd3
    } par_mode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_t;

    typedef struct packed {
        logic par;
        logic frm;
    } frame_err_t;
endpackage

// File: rtl/urx_baud_tick.sv
// Sampling tick source. A free-running prescaler emits one tick every
// 2^tap_sel clocks; tap 0 gives a tick on every clock.
// Assumes: tap_sel is held steady while a character is being received.
module urx_baud_tick #(
    parameter int PRESC_W = 12,
    parameter int TAP_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAP_W-1:0] tap_sel,
    output logic             tick
);
    logic [PRESC_W-1:0] presc;
    logic [PRESC_W-1:0] mask;

    // Free-running prescaler count.
    always_ff @(posedge clk) begin
        if (!rst_n) presc <= '0;
        else        presc <= presc + 1'b1;
    end

    // Mask of the low tap_sel bits of the prescaler.
    always_comb begin
        for (int i = 0; i < PRESC_W; i++) mask[i] = (i < int'(tap_sel));
    end

    // A tick fires when all of the masked prescaler bits are ones.
    assign tick = ((presc & mask) == mask);

    assert_tap0_every_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_sel == '0) |-> tick);
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && tap_sel != '0 && $stable(tap_sel)) |=> !tick);
endmodule

// File: rtl/urx_frame_fsm.sv
// Character framing engine. Confirms the start bit after half a bit period,
// then samples data, parity and stop bits one full bit period apart.
// Emits a one-clock frame_done together with the byte and its error flags.
// Assumes: rxd is already synchronised, and bit_div >= 2.
module urx_frame_fsm
    import urx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rxd,
    input  logic              tick,
    input  logic [CNT_W-1:0]  bit_div,
    input  par_mode_t         par_mode,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_data,
    output frame_err_t        frame_err
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    rx_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   limit;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  shreg;
    logic               par_acc;
    logic               par_bit;
    logic               par_bad;
    logic               at_sample;

    // Tick count that ends the current wait: half a bit while confirming the start bit.
    assign limit     = (state == S_START) ? (bit_div >> 1) - 1'b1 : bit_div - 1'b1;
    assign at_sample = tick && (cnt == limit);

    // Parity verdict from the data parity and the received parity bit.
    always_comb begin
        unique case (par_mode)
            PAR_EVEN: par_bad = par_acc ^ par_bit;
            PAR_ODD:  par_bad = ~(par_acc ^ par_bit);
            PAR_ZERO: par_bad = par_bit;
            default:  par_bad = 1'b0;
        endcase
    end

    // Sequencer: state, tick counter, bit index and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            cnt        <= '0;
            idx        <= '0;
            shreg      <= '0;
            par_acc    <= 1'b0;
            par_bit    <= 1'b0;
            frame_done <= 1'b0;
            frame_data <= '0;
            frame_err  <= '0;
        end else begin
            frame_done <= 1'b0;
            if (!rx_en) begin
                state <= S_IDLE;
                cnt   <= '0;
            end else begin
                if (state != S_IDLE && tick) cnt <= at_sample ? '0 : cnt + 1'b1;
                unique case (state)
                    S_IDLE: if (!rxd) begin
                        state <= S_START;
                        cnt   <= '0;
                    end
                    S_START: if (at_sample) begin
                        state   <= rxd ? S_IDLE : S_DATA;
                        idx     <= '0;
                        par_acc <= 1'b0;
                        par_bit <= 1'b0;
                    end
                    S_DATA: if (at_sample) begin
                        shreg   <= {rxd, shreg[DATA_W-1:1]};
                        par_acc <= par_acc ^ rxd;
                        idx     <= idx + 1'b1;
                        if (idx == LAST_IDX) state <= (par_mode == PAR_NONE) ? S_STOP : S_PAR;
                    end
                    S_PAR: if (at_sample) begin
                        par_bit <= rxd;
                        state   <= S_STOP;
                    end
                    S_STOP: if (at_sample) begin
                        frame_done    <= 1'b1;
                        frame_data    <= shreg;
                        frame_err.frm <= ~rxd;
                        frame_err.par <= par_bad;
                        state         <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    assert_done_after_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(rx_en));
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

// File: rtl/uart_rx_route.sv
// Serial receiver top. Synchronises the line, times the bits, holds the
// receive byte and the sticky error flags, and routes the two interrupts.
// Assumes: buf_rd and stat_rd are one-clock pulses from the reading side.
module uart_rx_route
    import urx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 8,
    parameter int PRESC_W = 12,
    parameter int TAP_W   = 4,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_in,
    input  logic [TAP_W-1:0]  tap_sel,
    input  logic [CNT_W-1:0]  bit_div,
    input  logic [1:0]        par_mode,
    input  logic              err_route,
    input  logic              buf_rd,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              err_par,
    output logic              err_frm,
    output logic              err_ovr,
    output logic              irq_done,
    output logic              irq_err
);
    logic [SYNC_N-1:0]  sync_q;
    logic               tick;
    logic               frame_done;
    logic [DATA_W-1:0]  frame_data;
    frame_err_t         frame_err;
    logic               buf_full;
    logic               take;
    logic               new_ovr;
    logic               any_err;

    // Line synchroniser chain; resets to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_N-2:0], rx_in};
    end

    urx_baud_tick #(.PRESC_W(PRESC_W), .TAP_W(TAP_W)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_sel (tap_sel),
        .tick    (tick)
    );

    urx_frame_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .rxd        (sync_q[SYNC_N-1]),
        .tick       (tick),
        .bit_div    (bit_div),
        .par_mode   (par_mode_t'(par_mode)),
        .frame_done (frame_done),
        .frame_data (frame_data),
        .frame_err  (frame_err)
    );

    // Error classification of a character that is accepted in this clock.
    assign take    = frame_done && rx_en;
    assign new_ovr = buf_full && !buf_rd;
    assign any_err = frame_err.par || frame_err.frm || new_ovr;

    // Receive byte, occupancy, sticky flags and interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            buf_full <= 1'b0;
            err_par  <= 1'b0;
            err_frm  <= 1'b0;
            err_ovr  <= 1'b0;
            irq_done <= 1'b0;
            irq_err  <= 1'b0;
        end else begin
            irq_done <= 1'b0;
            irq_err  <= 1'b0;
            if (buf_rd) buf_full <= 1'b0;
            if (stat_rd) begin
                err_par <= 1'b0;
                err_frm <= 1'b0;
                err_ovr <= 1'b0;
            end
            if (take) begin
                rx_data  <= frame_data;
                buf_full <= 1'b1;
                if (frame_err.par) err_par <= 1'b1;
                if (frame_err.frm) err_frm <= 1'b1;
                if (new_ovr)       err_ovr <= 1'b1;
                irq_err  <= any_err;
                irq_done <= !any_err || !err_route;
            end
        end
    end

    assert_disabled_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !stat_rd) |=> ($stable(rx_data) && $stable({err_par, err_frm, err_ovr})
                                  && !irq_done && !irq_err));
    assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_en && buf_full && !buf_rd) |=> (err_ovr && irq_err));
    assert_route_masks_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_err && $past(err_route)) |-> !irq_done);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);
    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |=> !irq_err);
    assert_flag_needs_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_frm) |-> irq_err);
endmodule

// File: tb/uart_rx_route_tb_top.sv
module uart_rx_route_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       rx_in = 1'b1;
    logic [3:0] tap_sel = 4'd0;
    logic [7:0] bit_div = 8'd16;
    logic [1:0] par_mode = 2'd0;
    logic       err_route = 1'b0;
    logic       buf_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rx_data;
    logic       err_par, err_frm, err_ovr, irq_done, irq_err;

    int checks = 0;
    int errors = 0;
    int n_done = 0;
    int n_err = 0;
    int wide_pulses = 0;
    logic prev_done = 1'b0;
    logic prev_err = 1'b0;
    bit finished = 1'b0;

    // bench model state
    logic       m_full = 1'b0;
    logic       m_par = 1'b0, m_frm = 1'b0, m_ovr = 1'b0;
    logic [7:0] m_data = 8'h00;

    always #10 clk = ~clk;

    uart_rx_route dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_in(rx_in),
        .tap_sel(tap_sel), .bit_div(bit_div), .par_mode(par_mode),
        .err_route(err_route), .buf_rd(buf_rd), .stat_rd(stat_rd),
        .rx_data(rx_data), .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr),
        .irq_done(irq_done), .irq_err(irq_err)
    );

    // interrupt pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (irq_done) n_done++;
        if (irq_err)  n_err++;
        if ((irq_done && prev_done) || (irq_err && prev_err)) wide_pulses++;
        prev_done = irq_done;
        prev_err  = irq_err;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic par_bit_of(input logic [7:0] d, input logic [1:0] pm);
        case (pm)
            2'd1:    return ^d;
            2'd2:    return ~(^d);
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive_bit(input logic v, input int bclk);
        rx_in = v;
        repeat (bclk) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic flip, input logic stop_v, input int bclk);
        drive_bit(1'b0, bclk);
        for (int i = 0; i < 8; i++) drive_bit(d[i], bclk);
        if (par_mode != 2'd0) drive_bit(par_bit_of(d, par_mode) ^ flip, bclk);
        drive_bit(stop_v, bclk);
        drive_bit(1'b1, 2 * bclk);
    endtask

    task automatic read_pulse(input logic do_buf, input logic do_stat);
        buf_rd = do_buf;
        stat_rd = do_stat;
        @(negedge clk);
        buf_rd = 1'b0;
        stat_rd = 1'b0;
        if (do_buf)  m_full = 1'b0;
        if (do_stat) begin m_par = 0; m_frm = 0; m_ovr = 0; end
    endtask

    // send one character and check byte, flags and interrupts against the model
    task automatic frame_and_check(input string tag, input logic [7:0] d, input logic flip,
                                   input logic stop_v, input int bclk);
        int d0, e0;
        logic ep, ef, eo, anye;
        d0 = n_done;
        e0 = n_err;
        ep = flip && (par_mode != 2'd0);
        ef = !stop_v;
        eo = m_full;
        anye = ep || ef || eo;
        send_frame(d, flip, stop_v, bclk);
        m_data = d;
        m_full = 1'b1;
        m_par |= ep;
        m_frm |= ef;
        m_ovr |= eo;
        chk({tag, " R4 data"}, rx_data, m_data);
        chk({tag, " R5 err_par"}, err_par, m_par);
        chk({tag, " R6 err_frm"}, err_frm, m_frm);
        chk({tag, " R7 err_ovr"}, err_ovr, m_ovr);
        chk({tag, " R8 irq_err count"}, n_err - e0, anye ? 1 : 0);
        chk({tag, " R8 irq_done count"}, n_done - d0, (!anye || !err_route) ? 1 : 0);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        int d0, e0;
        logic [7:0] held;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("reset R4 rx_data", rx_data, 0);
        chk("reset R10 flags", {err_par, err_frm, err_ovr}, 0);
        chk("reset R9 irqs", {irq_done, irq_err}, 0);

        rx_en = 1'b1;
        repeat (8) @(negedge clk);
        par_mode = 2'd1;
        frame_and_check("directed even", 8'hA5, 1'b0, 1'b1, 16);
        read_pulse(1, 1);

        // constrained random characters
        for (int k = 0; k < 24; k++) begin
            logic [7:0] d;
            logic flip, stop_v, rd;
            d = 8'($urandom);
            par_mode = 2'($urandom);
            err_route = 1'($urandom);
            flip = ($urandom % 4) == 0;
            stop_v = ($urandom % 6) != 0;
            rd = ($urandom % 4) != 0;
            if (rd) begin
                read_pulse(1, 1);
                chk("random R10 cleared", {err_par, err_frm, err_ovr}, 0);
            end
            frame_and_check("random", d, flip, stop_v, 16);
        end

        // overrun persists until the byte is read (R7)
        read_pulse(1, 1);
        par_mode = 2'd0;
        err_route = 1'b1;
        frame_and_check("ovr first", 8'h11, 0, 1, 16);
        frame_and_check("ovr second R7", 8'h22, 0, 1, 16);
        frame_and_check("ovr third R7", 8'h33, 0, 1, 16);
        read_pulse(1, 0);
        chk("R10 sticky after buf_rd", err_ovr, 1);
        read_pulse(0, 1);
        frame_and_check("after read R7", 8'h44, 0, 1, 16);
        read_pulse(1, 1);

        // forced-zero parity and framing, route 0 (R5, R6, R8)
        par_mode = 2'd3;
        err_route = 1'b0;
        frame_and_check("zero par R5", 8'hFF, 1'b1, 1'b1, 16);
        read_pulse(1, 1);
        frame_and_check("bad stop R6", 8'h5A, 1'b0, 1'b0, 16);
        read_pulse(1, 1);

        // short start glitch is rejected (R3)
        held = rx_data;
        d0 = n_done;
        e0 = n_err;
        rx_in = 1'b0;
        repeat (3) @(negedge clk);
        rx_in = 1'b1;
        repeat (60) @(negedge clk);
        chk("glitch R3 data", rx_data, held);
        chk("glitch R3 irqs", (n_done - d0) + (n_err - e0), 0);
        frame_and_check("after glitch R3", 8'hC3, 0, 1, 16);
        read_pulse(1, 1);

        // abort mid-character (R1)
        held = rx_data;
        d0 = n_done;
        e0 = n_err;
        par_mode = 2'd0;
        drive_bit(1'b0, 16);
        for (int i = 0; i < 4; i++) drive_bit(1'b0, 16);
        rx_en = 1'b0;
        for (int i = 0; i < 4; i++) drive_bit(1'b0, 16);
        drive_bit(1'b1, 48);
        rx_en = 1'b1;
        repeat (8) @(negedge clk);
        chk("abort R1 data", rx_data, held);
        chk("abort R1 flags", {err_par, err_frm, err_ovr}, 0);
        chk("abort R1 irqs", (n_done - d0) + (n_err - e0), 0);
        // whole character while disabled, buffer still unread-free
        rx_en = 1'b0;
        send_frame(8'h0F, 0, 0, 16);
        chk("disabled R1 data", rx_data, held);
        chk("disabled R1 irqs", (n_done - d0) + (n_err - e0), 0);
        rx_en = 1'b1;
        repeat (8) @(negedge clk);

        // other prescaler taps (R2)
        tap_sel = 4'd2;
        bit_div = 8'd8;
        par_mode = 2'd2;
        frame_and_check("tap2 R2", 8'h96, 0, 1, 32);
        read_pulse(1, 1);
        tap_sel = 4'd3;
        bit_div = 8'd10;
        frame_and_check("tap3 R2", 8'h3C, 0, 1, 80);
        read_pulse(1, 1);

        chk("R9 single-clock pulses", wide_pulses, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule